// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register Window

This block is the software-facing register front end of an interrupt redirection controller. A 32-bit bus slave claims a 256-byte address window. Inside it sit two directly addressed registers: a select register that holds an indirect index, and a data window through which the register named by that index is read or written. The indirect space holds a controller identifier, a read-only version word, an arbitration alias of the identifier, and a table of 64-bit redirection entries, each reached as a lower and an upper 32-bit half.

The block stores the redirection table and the identifier. The table goes to the routing logic as one flat read-only vector. Two one-cycle events go with it: one when an entry's mask bit changes, and one whenever any entry is rewritten. Interrupt servicing and message delivery belong to the routing logic and are not part of this block.

Each entry has this layout: vector in bits 7:0, delivery mode in 10:8, destination mode in 11, polarity in 13, remote-IRR in 14, trigger mode in 15 (1 = level), mask in 16, destination in 63:56.

Top module: `irq_regwin`

## Requirements
- R1: Only addresses from BASE_ADDR to BASE_ADDR+0xFF are claimed. An access outside that range gives no read-valid strobe and changes no state.
- R2: Offset 0x00 is the read/write select register and offset 0x10 is the data window. A read of any other offset in the window returns zero, and a write to it is ignored. Every read that hits the window raises rd_valid with rd_data exactly one cycle after the request.
- R3: req_size gives the access size in bytes. A write takes effect only when req_size is 4 or 8, and then uses wr_data. A write of any other size changes nothing.
- R4: Indirect index 0x01 reads as 0x11 in bits 7:0 and PINS-1 in bits 23:16, with all other bits zero. A write to it is ignored.
- R5: Indirect indices 0x00 and 0x02 both read the 4-bit identifier in bits 27:24, with all other bits zero. A write to index 0x00 loads the identifier from bits 27:24. A write to 0x02 is ignored.
- R6: For an index of 0x10 or more, the entry number is (index-0x10)>>1. An even index reaches bits 31:0 of that entry and an odd index reaches bits 63:32.
- R7: A write whose entry number is PINS or more is discarded. A read of such an index, or of any index from 0x03 to 0x0F, returns zero.
- R8: Writing the lower half of an entry stores bit 14 (remote-IRR) as zero, whatever value was written. Writing the upper half leaves bit 14 unchanged.
- R9: When a write changes an entry's mask bit (bit 16), mask_evt pulses for exactly one cycle in the cycle after the write. mask_pin then carries the entry number and mask_val the new mask value. A write that leaves the mask bit unchanged gives no pulse.
- R10: tbl_upd pulses for one cycle in the cycle after each accepted write to an entry, and at no other time.
- R11: After reset every entry reads with only its mask bit set (lower half 0x00010000, upper half 0). The select register and the identifier read zero.
- R12: Entry n appears on table_flat[n*64+63 : n*64], and it updates in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_size | input | 4 | Access size in bytes |
| wr_data | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| rd_data | output | 32 | Read data |
| table_flat | output | PINS*64 | All redirection entries, entry n at bits n*64+63:n*64 |
| mask_evt | output | 1 | One-cycle pulse: an entry's mask bit changed |
| mask_pin | output | PW | Entry number for mask_evt |
| mask_val | output | 1 | New mask value for mask_evt |
| tbl_upd | output | 1 | One-cycle pulse: an entry was written |

## Verification
Several properties are checked on every cycle: the read-valid strobe follows window-hit reads one for one, a rejected write size never produces a table-update pulse, a mask pulse always comes with a table-update pulse and agrees with the stored mask bit, a lower-half write always leaves remote-IRR cleared, and the select register changes only on a select write. Other behaviour needs the bench's scenarios: the exact index-to-entry-half mapping, the version and identifier encodings, the discarding of out-of-range entries and of accesses outside the window, and the reset contents. The bench sweeps every entry with computed patterns and then probes each boundary.

// File: rtl/irw_pkg.sv
package irw_pkg;
   localparam int unsigned ENT_W      = 64;
   localparam int unsigned BIT_RIRR   = 14;
   localparam int unsigned BIT_MASK   = 16;
   localparam logic [7:0]  VER_CODE   = 8'h11;
   localparam logic [7:0]  OFF_SELECT = 8'h00;
   localparam logic [7:0]  OFF_WINDOW = 8'h10;
   localparam logic [31:0] IDX_ID     = 32'h0;
   localparam logic [31:0] IDX_VER    = 32'h1;
   localparam logic [31:0] IDX_ARB    = 32'h2;
   localparam logic [31:0] IDX_TBL0   = 32'h10;

   typedef struct packed {
      logic sel_we;
      logic win_we;
      logic sel_re;
      logic win_re;
      logic rd_hit;
   } irw_dec_t;
endpackage

// File: rtl/irw_decode.sv
module irw_decode
   import irw_pkg::*;
#(
   parameter logic [31:0] BASE_ADDR = 32'hFEC0_0000
) (
   input  logic        req_valid,
   input  logic        req_write,
   input  logic [31:0] req_addr,
   input  logic [3:0]  req_size,
   output irw_dec_t    dec,
   output logic        size_ok
);
   logic hit;
   logic wr_ok;

   assign hit     = req_valid && (req_addr[31:8] == BASE_ADDR[31:8]);
   assign size_ok = (req_size == 4'd4) || (req_size == 4'd8);
   assign wr_ok   = hit && req_write && size_ok;

   always_comb begin
      dec        = '0;
      dec.rd_hit = hit && !req_write;
      dec.sel_we = wr_ok && (req_addr[7:0] == OFF_SELECT);
      dec.win_we = wr_ok && (req_addr[7:0] == OFF_WINDOW);
      dec.sel_re = dec.rd_hit && (req_addr[7:0] == OFF_SELECT);
      dec.win_re = dec.rd_hit && (req_addr[7:0] == OFF_WINDOW);
   end
endmodule

// File: rtl/irw_regfile.sv
module irw_regfile
   import irw_pkg::*;
#(
   parameter int PINS = 24,
   parameter int EW   = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel_we,
   input  logic          win_we,
   input  logic [31:0]   wdata,
   input  logic [31:0]   tbl_word,
   output logic [31:0]   sel_q,
   output logic [31:0]   win_word,
   output logic          tbl_we,
   output logic [EW-1:0] tbl_ent,
   output logic          tbl_hi,
   output logic          tbl_ok
);
   logic [3:0]  id_q;
   logic [31:0] idx_off;
   logic [31:0] ent_full;

   assign idx_off  = sel_q - IDX_TBL0;
   assign ent_full = idx_off >> 1;
   assign tbl_ok   = (sel_q >= IDX_TBL0) && (ent_full < 32'(PINS));
   assign tbl_ent  = ent_full[EW-1:0];
   assign tbl_hi   = idx_off[0];
   assign tbl_we   = win_we && tbl_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= '0;
         id_q  <= '0;
      end else begin
         if (sel_we) sel_q <= wdata;
         if (win_we && sel_q == IDX_ID) id_q <= wdata[27:24];
      end
   end

   always_comb begin
      if (sel_q == IDX_ID || sel_q == IDX_ARB)
         win_word = {4'h0, id_q, 24'h0};
      else if (sel_q == IDX_VER)
         win_word = {8'h0, 8'(PINS - 1), 8'h0, VER_CODE};
      else if (tbl_ok)
         win_word = tbl_word;
      else
         win_word = '0;
   end

   // R2: the select register moves only on a select write
   p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_we |=> $stable(sel_q));
endmodule

// File: rtl/irw_table.sv
module irw_table
   import irw_pkg::*;
#(
   parameter int PINS = 24,
   parameter int EW   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [EW-1:0]      ent,
   input  logic               hi,
   input  logic               ok,
   input  logic [31:0]        wdata,
   output logic [31:0]        rd_word,
   output logic [PINS*64-1:0] flat,
   output logic               mask_evt,
   output logic [EW-1:0]      mask_pin,
   output logic               mask_val,
   output logic               upd
);
   logic [ENT_W-1:0] ents [PINS];
   logic [ENT_W-1:0] cur;

   assign cur     = ok ? ents[ent] : '0;
   assign rd_word = hi ? cur[63:32] : cur[31:0];

   for (genvar g = 0; g < PINS; g++) begin : g_ent
      logic wr_g;
      assign wr_g = we && (ent == EW'(g));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ents[g] <= 64'(1) << BIT_MASK;
         end else if (wr_g) begin
            if (hi) ents[g][63:32] <= wdata;
            else    ents[g][31:0]  <= wdata & ~(32'(1) << BIT_RIRR);
         end
      end
      assign flat[g*64 +: 64] = ents[g];

      // R8: a lower-half write leaves remote-IRR cleared
      p_rirr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_g && !hi) |=> !ents[g][BIT_RIRR]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_evt <= 1'b0;
         mask_pin <= '0;
         mask_val <= 1'b0;
         upd      <= 1'b0;
      end else begin
         upd      <= we;
         mask_evt <= we && !hi && (wdata[BIT_MASK] != cur[BIT_MASK]);
         mask_pin <= ent;
         mask_val <= wdata[BIT_MASK];
      end
   end

   // R9: a mask event accompanies a table update and agrees with the stored bit
   p_mask_upd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mask_evt |-> (upd && ents[mask_pin][BIT_MASK] == mask_val));
endmodule

// File: rtl/irq_regwin.sv
module irq_regwin
   import irw_pkg::*;
#(
   parameter int          PINS      = 24,
   parameter logic [31:0] BASE_ADDR = 32'hFEC0_0000,
   localparam int         PW        = (PINS > 1) ? $clog2(PINS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [31:0]        req_addr,
   input  logic [3:0]         req_size,
   input  logic [31:0]        wr_data,
   output logic               rd_valid,
   output logic [31:0]        rd_data,
   output logic [PINS*64-1:0] table_flat,
   output logic               mask_evt,
   output logic [PW-1:0]      mask_pin,
   output logic               mask_val,
   output logic               tbl_upd
);
   if (PINS < 1 || PINS > 120) begin : g_bad_pins
      $error("irq_regwin: PINS must lie in 1..120");
   end
   if (BASE_ADDR[7:0] != 8'h00) begin : g_bad_base
      $error("irq_regwin: BASE_ADDR must be 256-byte aligned");
   end

   irw_dec_t       dec;
   logic           size_ok;
   logic [31:0]    sel_q;
   logic [31:0]    win_word;
   logic [31:0]    tbl_word;
   logic           tbl_we;
   logic [PW-1:0]  tbl_ent;
   logic           tbl_hi;
   logic           tbl_ok;

   irw_decode #(.BASE_ADDR(BASE_ADDR)) u_dec (
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_size(req_size), .dec(dec), .size_ok(size_ok));

   irw_regfile #(.PINS(PINS), .EW(PW)) u_regs (
      .clk(clk), .rst_n(rst_n), .sel_we(dec.sel_we), .win_we(dec.win_we),
      .wdata(wr_data), .tbl_word(tbl_word), .sel_q(sel_q), .win_word(win_word),
      .tbl_we(tbl_we), .tbl_ent(tbl_ent), .tbl_hi(tbl_hi), .tbl_ok(tbl_ok));

   irw_table #(.PINS(PINS), .EW(PW)) u_tbl (
      .clk(clk), .rst_n(rst_n), .we(tbl_we), .ent(tbl_ent), .hi(tbl_hi),
      .ok(tbl_ok), .wdata(wr_data), .rd_word(tbl_word), .flat(table_flat),
      .mask_evt(mask_evt), .mask_pin(mask_pin), .mask_val(mask_val),
      .upd(tbl_upd));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= dec.rd_hit;
         if (dec.rd_hit)
            rd_data <= dec.sel_re ? sel_q : (dec.win_re ? win_word : 32'h0);
      end
   end

   // R2: read-valid strobe follows window-hit reads one for one
   p_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dec.rd_hit |=> rd_valid);
   p_rvalid_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !dec.rd_hit |=> !rd_valid);
   // R3: a write of an unsupported size never updates the table
   p_bad_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && !size_ok) |=> !tbl_upd);
endmodule

// File: tb/irq_regwin_tb.sv
module irq_regwin_tb;
   localparam int PINS = 24;
   localparam int PW   = $clog2(PINS);
   localparam logic [31:0] BASE = 32'hFEC0_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [31:0] req_addr = '0;
   logic [3:0]  req_size = '0;
   logic [31:0] wr_data = '0;
   logic rd_valid;
   logic [31:0] rd_data;
   logic [PINS*64-1:0] table_flat;
   logic mask_evt, mask_val, tbl_upd;
   logic [PW-1:0] mask_pin;

   always #2.5 clk = ~clk;

   irq_regwin #(.PINS(PINS), .BASE_ADDR(BASE)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .wr_data(wr_data),
      .rd_valid(rd_valid), .rd_data(rd_data), .table_flat(table_flat),
      .mask_evt(mask_evt), .mask_pin(mask_pin), .mask_val(mask_val),
      .tbl_upd(tbl_upd));

   int n_cmp = 0, n_bad = 0;
   logic [63:0] exp_tbl [PINS];
   logic c_evt, c_val, c_upd, c_rv;
   logic [PW-1:0] c_pin;
   logic [31:0] c_rd;

   task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [31:0] a, input logic [3:0] sz, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1; req_write = 1; req_addr = a; req_size = sz; wr_data = d;
      @(negedge clk);
      req_valid = 0; req_write = 0;
      c_evt = mask_evt; c_pin = mask_pin; c_val = mask_val; c_upd = tbl_upd;
   endtask

   task automatic rd(input logic [31:0] a);
      @(negedge clk);
      req_valid = 1; req_write = 0; req_addr = a; req_size = 4'd4;
      @(negedge clk);
      req_valid = 0;
      c_rv = rd_valid; c_rd = rd_data;
   endtask

   task automatic rd_idx(input logic [31:0] idx, input string req, input logic [31:0] exp);
      wr(BASE, 4'd4, idx);
      rd(BASE + 32'h10);
      chk({req, " rvalid"}, 64'(c_rv), 64'd1);
      chk(req, 64'(c_rd), 64'(exp));
   endtask

   task automatic chk_flat(input string req);
      for (int i = 0; i < PINS; i++)
         chk(req, table_flat[i*64 +: 64], exp_tbl[i]);
   endtask

   initial begin
      int cyc = 0;
      while (cyc < 100000) begin @(posedge clk); cyc++; end
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] lo, hi;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R11: reset contents
      for (int i = 0; i < PINS; i++) exp_tbl[i] = 64'h0000_0000_0001_0000;
      chk_flat("R11 reset table");
      chk("R11 idle pulses", {61'd0, mask_evt, tbl_upd, rd_valid}, 64'd0);
      rd(BASE);
      chk("R11 select reset", 64'(c_rd), 64'd0);
      rd_idx(32'h0, "R11 id reset", 32'h0);
      rd_idx(32'h10 + 32'(2*(PINS-1)), "R11 entry lo reset", 32'h0001_0000);
      rd_idx(32'h11, "R11 entry hi reset", 32'h0);

      // R4 version
      rd_idx(32'h1, "R4 version", {8'h0, 8'(PINS-1), 8'h0, 8'h11});
      wr(BASE + 32'h10, 4'd4, 32'hFFFF_FFFF);
      rd(BASE + 32'h10);
      chk("R4 version write ignored", 64'(c_rd), 64'({8'h0, 8'(PINS-1), 8'h0, 8'h11}));

      // R5 identifier
      wr(BASE, 4'd4, 32'h0);
      wr(BASE + 32'h10, 4'd8, 32'hF9AB_CDEF);
      rd_idx(32'h0, "R5 id idx0", 32'h0900_0000);
      rd_idx(32'h2, "R5 id idx2", 32'h0900_0000);
      wr(BASE + 32'h10, 4'd4, 32'h0500_0000);
      rd_idx(32'h0, "R5 idx2 write ignored", 32'h0900_0000);

      // R6 R8 R9 R10 R12: sweep every entry
      for (int i = 0; i < PINS; i++) begin
         lo = (32'(i) * 32'h0001_0203) ^ 32'h5A5A_4000;
         lo[16] = i[0];
         hi = 32'hA500_0000 + 32'(i) * 32'h0101_0101;
         wr(BASE, 4'd4, 32'h10 + 32'(2*i));
         wr(BASE + 32'h10, (i % 2 == 0) ? 4'd4 : 4'd8, lo);
         exp_tbl[i][31:0] = lo & ~32'h4000;
         chk("R10 upd after lo write", 64'(c_upd), 64'd1);
         chk("R9 mask pulse", 64'(c_evt), 64'(i % 2 == 0));
         if (i % 2 == 0) begin
            chk("R9 mask pin", 64'(c_pin), 64'(i));
            chk("R9 mask val", 64'(c_val), 64'd0);
         end
         chk("R8 R12 lo in flat", table_flat[i*64 +: 64], exp_tbl[i]);
         wr(BASE, 4'd4, 32'h11 + 32'(2*i));
         wr(BASE + 32'h10, 4'd4, hi);
         exp_tbl[i][63:32] = hi;
         chk("R10 upd after hi write", 64'(c_upd), 64'd1);
         chk("R9 no pulse on hi write", 64'(c_evt), 64'd0);
         chk("R12 hi in flat", table_flat[i*64 +: 64], exp_tbl[i]);
      end
      chk_flat("R12 full table");
      for (int i = 0; i < PINS; i++) begin
         rd_idx(32'h10 + 32'(2*i), "R6 even half", exp_tbl[i][31:0]);
         rd_idx(32'h11 + 32'(2*i), "R6 odd half", exp_tbl[i][63:32]);
      end
      // R9: rewrite lower half with same mask, then toggle back on
      wr(BASE, 4'd4, 32'h10);
      wr(BASE + 32'h10, 4'd4, exp_tbl[0][31:0]);
      chk("R9 unchanged mask no pulse", 64'(c_evt), 64'd0);
      wr(BASE + 32'h10, 4'd4, exp_tbl[0][31:0] | 32'h0001_0000);
      exp_tbl[0][16] = 1'b1;
      chk("R9 set mask pulse", {62'd0, c_evt, c_val}, 64'd3);
      chk("R9 set mask pin", 64'(c_pin), 64'd0);

      // R7 out-of-range entries and reserved indices
      wr(BASE, 4'd4, 32'h10 + 32'(2*PINS));
      wr(BASE + 32'h10, 4'd4, 32'h1234_5678);
      chk("R7 no upd", 64'(c_upd), 64'd0);
      chk_flat("R7 table unchanged");
      rd_idx(32'h10 + 32'(2*PINS), "R7 out-of-range read", 32'h0);
      rd_idx(32'h11 + 32'(2*PINS), "R7 out-of-range hi read", 32'h0);
      for (int k = 3; k < 16; k++)
         rd_idx(32'(k), "R7 reserved index read", 32'h0);

      // R3 sizes
      wr(BASE, 4'd4, 32'h12);
      wr(BASE, 4'd1, 32'h0);
      wr(BASE, 4'd2, 32'h0);
      wr(BASE + 32'h10, 4'd2, 32'h0);
      chk("R3 small write no upd", 64'(c_upd), 64'd0);
      rd(BASE);
      chk("R3 select kept", 64'(c_rd), 64'h12);
      chk_flat("R3 table unchanged");

      // R2 other offsets
      rd(BASE + 32'h20);
      chk("R2 other offset rvalid", 64'(c_rv), 64'd1);
      chk("R2 other offset zero", 64'(c_rd), 64'd0);
      wr(BASE + 32'h04, 4'd4, 32'h99);
      rd(BASE);
      chk("R2 other offset write ignored", 64'(c_rd), 64'h12);

      // R1 outside the window
      rd(BASE + 32'h100);
      chk("R1 no rvalid outside", 64'(c_rv), 64'd0);
      wr(BASE + 32'h100, 4'd4, 32'h55);
      wr(BASE - 32'h100 + 32'h10, 4'd4, 32'hFFFF_FFFF);
      chk("R1 no upd outside", 64'(c_upd), 64'd0);
      rd(BASE);
      chk("R1 select unchanged", 64'(c_rd), 64'h12);
      chk_flat("R1 table unchanged");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule